// File: doc/BRIEF.md
# Sticky Interrupt Status with Per-Line Error Flags

This block keeps the event flags of a storage-card host controller. The command engine and the data paths each raise one-cycle set pulses. Each pulse sets a sticky flag, and the flag stays set until software clears it by writing a one to its bit position on a simple register bus.

A mask register, with the same bit layout, selects which flags assert the single interrupt output. The status word also reports live, read-only information: the sampled levels of the eight card data lines, and two busy indicators. A separate card-busy output goes high while data lines 0 to 3 are all low.

Top module: `irq_status_top`

## Requirements
- R1: After reset, all sticky flags (status bits [15:0]) and all mask bits read as zero, and the interrupt output is low.
- R2: A set pulse on event input bit k makes status bit k read as 1 from the cycle after the pulse. The bit stays 1 until it is cleared. Flags are: bits [7:0] receive CRC error per data line, 8 transmit CRC error, 9 descriptor error, 10 response CRC error, 11 response timeout, 12 descriptor timeout, 13 end of chain, 14 response done, 15 card interrupt.
- R3: A bus write to the status address (addr 0) clears exactly the sticky bits in [15:0] whose write-data bit is 1. The other flags are unchanged.
- R4: If a set pulse and a write-one-clear hit the same bit in the same cycle, the bit ends up set.
- R5: A bus write to the mask address (addr 1) loads mask bits [15:0] from write data. Reads of addr 1 return the mask, with the upper bits zero.
- R6: irq_o is high exactly when (status AND mask) over bits [15:0] is nonzero, one cycle after the register update.
- R7: A read of the status address returns the live data-line levels in [23:16], the descriptor-engine busy flag in bit 30, and the controller busy flag in bit 31, all sampled in the same cycle. Bits [29:24] read as zero.
- R8: Write data in bits [31:16] of a status write has no effect on any stored state.
- R9: card_busy_o is high exactly when data lines 0 to 3 are all low.
- R10: Read data is combinational from the address and is zero for any address other than 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 16 | One-cycle set pulses, one per sticky flag |
| dat_lvl_i | input | 8 | Sampled card data-line levels |
| desc_busy_i | input | 1 | Descriptor engine busy |
| ctrl_busy_i | input | 1 | Controller busy |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 status, 1 mask |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request |
| card_busy_o | output | 1 | Card holding lines 0 to 3 low |

## Verification
The bench goes after a set and a clear landing on the same bit in the same cycle. A design that lets the clear win would lose an event, and status would read zero where one is expected.

It writes all-ones into the read-only fields and checks that the live levels and the mask do not change. A design that stored those bits would echo them back.

It sweeps mask and status against each other, because a design that ORs unmasked flags would raise the interrupt while the mask is zero. It also walks the low data-line combinations, where a design that decodes all eight lines, or uses OR instead of AND, would report the wrong card-busy value.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned NUM_DAT   = 8;
  localparam int unsigned NUM_EVT   = 16;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned DAT_LSB   = 16;
  localparam int unsigned DESC_BIT  = 30;
  localparam int unsigned CTRL_BIT  = 31;
  localparam int unsigned BUSY_LINES = 4;

  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_sel_e;

  function automatic logic [NUM_EVT-1:0] sticky_next(
    input logic [NUM_EVT-1:0] cur,
    input logic [NUM_EVT-1:0] set,
    input logic [NUM_EVT-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  function automatic logic lines_busy(input logic [NUM_DAT-1:0] lvl);
    return ~|lvl[BUSY_LINES-1:0];
  endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
  import irq_status_pkg::*;
#(
  parameter int unsigned W = NUM_EVT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (!rst_ni) flags_q[g] <= 1'b0;
      else         flags_q[g] <= (flags_q[g] & ~clr_i[g]) | set_i[g];
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flags_q[g]) else $error("set lost"); // R4
    AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[g] && !clr_i[g]) |=> flags_q[g]) else $error("flag dropped"); // R2
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_status_pkg::*;
#(
  parameter int unsigned W = NUM_EVT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= data_i;
  end

  assign mask_o = mask_q;

  AST_MASK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mask_q)) else $error("mask moved"); // R5
endmodule

// File: rtl/irq_status_top.sv
module irq_status_top
  import irq_status_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_EVT-1:0]  evt_set_i,
  input  logic [NUM_DAT-1:0]  dat_lvl_i,
  input  logic                desc_busy_i,
  input  logic                ctrl_busy_i,
  input  logic                bus_we_i,
  input  logic                bus_addr_i,
  input  logic [BUS_W-1:0]    bus_wdata_i,
  output logic [BUS_W-1:0]    bus_rdata_o,
  output logic                irq_o,
  output logic                card_busy_o
);
  logic [NUM_EVT-1:0] flags, mask, clr_req;
  logic               wr_status, wr_mask;
  logic               irq_q;

  assign wr_status = bus_we_i && (reg_sel_e'(bus_addr_i) == REG_STATUS);
  assign wr_mask   = bus_we_i && (reg_sel_e'(bus_addr_i) == REG_MASK);
  assign clr_req   = wr_status ? bus_wdata_i[NUM_EVT-1:0] : '0;

  irq_sticky_bank #(.W(NUM_EVT)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt_set_i),
    .clr_i(clr_req), .flags_o(flags)
  );

  irq_mask_reg #(.W(NUM_EVT)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_mask),
    .data_i(bus_wdata_i[NUM_EVT-1:0]), .mask_o(mask)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sticky_next(flags, evt_set_i, clr_req)
                            & (wr_mask ? bus_wdata_i[NUM_EVT-1:0] : mask));
  end
  assign irq_o = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (reg_sel_e'(bus_addr_i) == REG_STATUS) begin
      bus_rdata_o[NUM_EVT-1:0]               = flags;
      bus_rdata_o[DAT_LSB +: NUM_DAT]        = dat_lvl_i;
      bus_rdata_o[DESC_BIT]                  = desc_busy_i;
      bus_rdata_o[CTRL_BIT]                  = ctrl_busy_i;
    end else begin
      bus_rdata_o[NUM_EVT-1:0]               = mask;
    end
  end

  assign card_busy_o = lines_busy(dat_lvl_i);

  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(flags & mask)) else $error("irq mismatch"); // R6
  AST_CLEAR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && bus_wdata_i[0] && !evt_set_i[0]) |=> !flags[0]) else $error("clr"); // R3
  AST_BUSY_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_lvl_i[3:0] == 4'h0) |-> card_busy_o) else $error("busy"); // R9
  AST_RESET_IRQ: assert property (@(posedge clk_i)
    $past(!rst_ni) |-> (!irq_o && flags == '0 && mask == '0)) else $error("rst"); // R1
endmodule

// File: tb/irq_status_top_tb.sv
module irq_status_top_tb;
  logic        clk = 0, rst_n = 0;
  logic [15:0] evt = '0;
  logic [7:0]  dat = '0;
  logic        dbusy = 0, cbusy = 0, we = 0, addr = 0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, cardb;
  int          n_run = 0, n_fail = 0;
  logic [15:0] m_stat = '0, m_mask = '0;

  always #2 clk = ~clk;

  irq_status_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_set_i(evt), .dat_lvl_i(dat),
    .desc_busy_i(dbusy), .ctrl_busy_i(cbusy), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .card_busy_o(cardb)
  );

  function automatic logic [31:0] exp_status(logic [15:0] s, logic [7:0] d, logic db, logic cb);
    return {cb, db, 6'b0, d, s};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus and model update; outputs checked mid-low phase after
  task automatic step(logic [15:0] e, logic w, logic a, logic [31:0] wd);
    @(negedge clk);
    evt = e; we = w; addr = a; wdata = wd;
    @(posedge clk);
    if (w && !a) m_stat = m_stat & ~wd[15:0];
    m_stat = m_stat | e;
    if (w && a) m_mask = wd[15:0];
    #1;
    evt = '0; we = 0;
  endtask

  task automatic read_all(string req);
    @(negedge clk);
    addr = 0;
    #0.5 check({req, " status"}, rdata, exp_status(m_stat, dat, dbusy, cbusy));
    addr = 1;
    #0.5 check({req, " mask"}, rdata, {16'h0, m_mask});
    check({req, " irq R6"}, {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    read_all("R1");
    // R2: set single bits
    step(16'h0101, 0, 0, 0); read_all("R2");
    step(16'h8000, 0, 0, 0); read_all("R2 hold");
    // R5 mask load
    step(0, 1, 1, 32'hFFFF_8001); read_all("R5");
    // R3 clear subset
    step(0, 1, 0, 32'h0000_0100); read_all("R3");
    // R4 set and clear same cycle
    step(16'h0002, 1, 0, 32'h0000_0002); read_all("R4");
    // R8 upper write bits ignored
    dat = 8'hA5; dbusy = 1; cbusy = 1;
    step(0, 1, 0, 32'hFFFF_0000); read_all("R8");
    // R7 live fields
    dat = 8'h3C; dbusy = 0; read_all("R7");
    // R10 read decode: only two addresses exist; mask upper zero
    @(negedge clk) addr = 1; #0.5 check("R10 upper", {16'h0, rdata[31:16]}, 32'h0);
    // R9 card busy on low lines
    for (int i = 0; i < 16; i++) begin
      @(negedge clk) dat = {4'hF, i[3:0]};
      #0.5 check("R9", {31'b0, cardb}, {31'b0, (i == 0)});
    end
    // R6 mask zero kills irq
    step(0, 1, 1, 32'h0); read_all("R6 zero mask");
    // random mix
    for (int k = 0; k < 300; k++) begin
      dat = 8'($urandom); dbusy = 1'($urandom); cbusy = 1'($urandom);
      step(16'($urandom) & 16'($urandom), 1'($urandom), 1'($urandom), $urandom);
      read_all("R2 R3 R6 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule